// File: doc/BRIEF.md
# Tagged Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It watches the line on every pulse of a sampling tick that runs at sixteen times the bit rate. It confirms each start bit at mid-bit, then samples every following bit at its centre. Each character is 5 to 8 bits long, sent least significant bit first. An optional parity bit and a stop bit follow the data.

Every received character leaves the block as one 12-bit word. The word holds the data and four status flags that belong to that character: framing error, parity error, line break and overrun. A receive buffer downstream takes the word through a valid/ready pair. The framing inputs are the same ones the companion transmitter uses.

If a new character completes while the previous word has not yet been accepted, the new character is discarded. The overrun flag is then raised on the word that is still waiting.

Top module: `serial_rx_tagged`

## Requirements
- R1: `cfg_len` selects the character length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. The first bit received lands in word bit 0. Word bits above the character length are zero.
- R2: A falling line starts a frame only if the line is still low on the 8th tick after the tick that saw it fall. A shorter low pulse produces no word.
- R3: The output word is laid out as data in bits [7:0], framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. `word_valid` rises one clock after the tick that samples the stop bit.
- R4: With parity enabled and stick mode off, `cfg_par_even`=1 expects an even number of ones over the data plus the parity bit, and 0 expects an odd number. A mismatch sets bit 9.
- R5: In stick mode (`cfg_par_stick`=1, parity enabled), the parity bit must be 0 when `cfg_par_even`=1 and 1 when it is 0. A mismatch sets bit 9.
- R6: With `cfg_par_en`=0, no parity bit is expected and bit 9 is always 0.
- R7: A stop bit sampled low sets bit 8. After that, the receiver waits for the line to go high before it looks for the next start.
- R8: A frame that is low at every sample, start through stop, produces exactly one word, 0x400: break set, data zero, no other flag. No further word appears until the line has returned high.
- R9: A word that is offered but not accepted (`word_valid`=1, `word_ready`=0) keeps `word_valid` high and its data bits unchanged.
- R10: If a character completes while a word is still pending, that character is discarded and bit 11 of the pending word is set. The next word after the pending one is accepted carries bit 11 clear.
- R11: During reset and directly after it, `word_valid` is 0 and `word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable, one pulse per 1/16 of a bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity select; in stick mode, selects a stuck-at-0 bit |
| cfg_par_stick | input | 1 | Stick parity mode |
| word_ready | input | 1 | Downstream buffer can take a word |
| word_valid | output | 1 | A word is offered |
| word | output | 12 | Character and status flags |

## Verification
The bench sends short low glitches that a receiver skipping mid-bit confirmation would turn into spurious characters. It sends a fully low frame that a naive design would report as a zero character with a framing error, or repeat while the line stays low. Stick parity is tried with both stuck values, and a wrong parity bit is sent on purpose: an inverted or ignored stick rule flips bit 9. A character is pushed against a stalled buffer to check that the held data survives, that the overrun bit appears on it rather than on the next word, and that it clears afterwards. Short characters are sent with the spare line bits high, so a design that leaves those bits in the shift register shows set upper bits.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int WORD_W  = 12;
    localparam int FE_POS  = 8;
    localparam int PE_POS  = 9;
    localparam int BRK_POS = 10;
    localparam int OVR_POS = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } rx_cfg_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_parity.sv
module rx_parity
    import serial_rx_pkg::*;
(
    input  rx_cfg_t cfg,
    input  logic    ones_odd,
    input  logic    par_bit,
    output logic    par_err
);
    logic stick_expect;

    always_comb begin
        stick_expect = ~cfg.par_even;
        par_err      = 1'b0;
        if (cfg.par_en) begin
            if (cfg.par_stick)     par_err = (par_bit != stick_expect);
            else if (cfg.par_even) par_err = ones_odd;
            else                   par_err = ~ones_odd;
        end
    end
endmodule

// File: rtl/rx_word_out.sv
module rx_word_out
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W+2:0] push_word,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W+3:0] word_o
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W+3:0] word;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.valid && ready_i) s_d.valid = 1'b0;
        if (push) begin
            if (s_q.valid && !ready_i) begin
                s_d.word[DATA_W+3] = 1'b1;
            end else begin
                s_d.word  = {1'b0, push_word};
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign word_o  = s_q.word;
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        rxd,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_par_en,
    input  logic        cfg_par_even,
    input  logic        cfg_par_stick,
    input  logic        word_ready,
    output logic        word_valid,
    output logic [11:0] word
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [BIT_W-1:0] MIN_LAST = BIT_W'(4);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shreg;
        logic              ones;
        logic              seen_high;
        logic              par_bit;
    } fsm_t;

    rx_cfg_t           cfg;
    logic              rx_s;
    logic              par_err;
    logic [BIT_W-1:0]  last_idx;
    logic [DATA_W-1:0] aligned;
    logic              push;
    logic [DATA_W+2:0] push_word;
    fsm_t              f_d, f_q;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en,
                   par_even: cfg_par_even, par_stick: cfg_par_stick};

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rxd),
        .sync_o  (rx_s)
    );

    rx_parity u_par (
        .cfg      (cfg),
        .ones_odd (f_q.ones),
        .par_bit  (f_q.par_bit),
        .par_err  (par_err)
    );

    always_comb begin
        last_idx = MIN_LAST + BIT_W'(cfg.len);
        aligned  = f_q.shreg >> (BIT_W'(DATA_W - 1) - last_idx);
    end

    always_comb begin
        f_d       = f_q;
        push      = 1'b0;
        push_word = '0;
        if (tick16) begin
            unique case (f_q.st)
                ST_IDLE: begin
                    if (!rx_s) begin
                        f_d.st        = ST_START;
                        f_d.cnt       = '0;
                        f_d.bitn      = '0;
                        f_d.shreg     = '0;
                        f_d.ones      = 1'b0;
                        f_d.seen_high = 1'b0;
                        f_d.par_bit   = 1'b0;
                    end
                end
                ST_START: begin
                    if (f_q.cnt == CNT_MID) begin
                        f_d.cnt = '0;
                        f_d.st  = rx_s ? ST_IDLE : ST_DATA;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (f_q.cnt == CNT_LAST) begin
                        f_d.cnt       = '0;
                        f_d.shreg     = {rx_s, f_q.shreg[DATA_W-1:1]};
                        f_d.ones      = f_q.ones ^ rx_s;
                        f_d.seen_high = f_q.seen_high | rx_s;
                        if (f_q.bitn == last_idx)
                            f_d.st = cfg.par_en ? ST_PARITY : ST_STOP;
                        else
                            f_d.bitn = f_q.bitn + 1'b1;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (f_q.cnt == CNT_LAST) begin
                        f_d.cnt       = '0;
                        f_d.par_bit   = rx_s;
                        f_d.ones      = f_q.ones ^ rx_s;
                        f_d.seen_high = f_q.seen_high | rx_s;
                        f_d.st        = ST_STOP;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (f_q.cnt == CNT_LAST) begin
                        f_d.cnt = '0;
                        push    = 1'b1;
                        if (!f_q.seen_high && !rx_s) begin
                            push_word = '0;
                            push_word[BRK_POS] = 1'b1;
                            f_d.st = ST_HOLD;
                        end else begin
                            push_word[DATA_W-1:0] = aligned;
                            push_word[FE_POS]     = ~rx_s;
                            push_word[PE_POS]     = par_err;
                            f_d.st = rx_s ? ST_IDLE : ST_HOLD;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rx_s) f_d.st = ST_IDLE;
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, default: '0};
        else        f_q <= f_d;
    end

    rx_word_out #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .ready_i   (word_ready),
        .valid_o   (word_valid),
        .word_o    (word)
    );
endmodule

// File: rtl/serial_rx_tagged_chk.sv
module serial_rx_tagged_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_len,
    input logic        word_ready,
    input logic        word_valid,
    input logic [11:0] word
);
    assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> word_valid);

    assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> $stable(word[10:0]));

    assert_break_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word[10]) |-> (word[9:0] == 10'd0));

    assert_overrun_on_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word[11]) |-> $past(word_valid));

    assert_short_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg_len == 2'd0) |-> (word[7:5] == 3'd0));
endmodule

bind serial_rx_tagged serial_rx_tagged_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .word_ready (word_ready),
    .word_valid (word_valid),
    .word       (word)
);

// File: tb/test_serial_rx_tagged.sv
`timescale 1ns/1ps
module test_serial_rx_tagged;

    typedef struct packed {
        logic [1:0]  len;
        logic        pen;
        logic        peven;
        logic        pstick;
        logic        bad;
        logic        stopv;
        logic [7:0]  data;
        logic [11:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 12'h0A5},
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 12'h03C},
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 12'h23C},
        '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 12'h001},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h7F, 12'h27F},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 12'h01F},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h2A, 12'h02A},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h15, 12'h215},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 12'h181},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 12'h155},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 12'h000}
    };
    localparam string TAGS [NVEC] = '{"R1/R6", "R4", "R4", "R4", "R4",
                                      "R1", "R5", "R5", "R7", "R7", "R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        rxd = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_even = 1'b0;
    logic        cfg_par_stick = 1'b0;
    logic        word_ready = 1'b1;
    logic        word_valid;
    logic [11:0] word;

    int          n_tests = 0;
    int          n_fail = 0;
    int          got_cnt = 0;
    logic [11:0] last_word = '0;
    int          tick_div = 0;

    always #2.5 clk = ~clk;

    serial_rx_tagged i_serial_rx_tagged (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16        (tick16),
        .rxd           (rxd),
        .cfg_len       (cfg_len),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .word_ready    (word_ready),
        .word_valid    (word_valid),
        .word          (word)
    );

    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        tick16  <= (tick_div == 0);
        if (rst_n && word_valid && word_ready) begin
            last_word = word;
            got_cnt   = got_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send(input int nb, input logic [7:0] d, input logic pen,
                        input logic pbit, input logic stopv);
        hold_line(1'b0, 64);
        for (int i = 0; i < nb; i++) hold_line(d[i], 64);
        if (pen) hold_line(pbit, 64);
        hold_line(stopv, 64);
        hold_line(1'b1, 128);
    endtask

    function automatic logic par_of(input vec_t v);
        logic [7:0] m;
        logic p;
        m = v.data & ((8'd1 << (5 + v.len)) - 8'd1);
        if (v.pstick)     p = ~v.peven;
        else if (v.peven) p = ^m;
        else              p = ~(^m);
        return p ^ v.bad;
    endfunction

    logic done = 1'b0;

    initial begin
        int n0;
        repeat (5) @(negedge clk);
        check("R11 valid in reset", {11'd0, word_valid}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 word after reset", word, 12'h000);
        check("R11 valid after reset", {11'd0, word_valid}, 12'd0);
        repeat (20) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            cfg_len       = VECS[k].len;
            cfg_par_en    = VECS[k].pen;
            cfg_par_even  = VECS[k].peven;
            cfg_par_stick = VECS[k].pstick;
            n0 = got_cnt;
            send(5 + int'(VECS[k].len), VECS[k].data, VECS[k].pen,
                 par_of(VECS[k]), VECS[k].stopv);
            check({TAGS[k], " R3 word count"}, 12'(got_cnt - n0), 12'd1);
            check({TAGS[k], " R3 word"}, last_word, VECS[k].exp);
        end

        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_par_stick = 1'b0;

        n0 = got_cnt;
        hold_line(1'b0, 12);
        hold_line(1'b1, 192);
        hold_line(1'b0, 24);
        hold_line(1'b1, 192);
        check("R2 glitches ignored", 12'(got_cnt - n0), 12'd0);

        n0 = got_cnt;
        hold_line(1'b0, 64 * 14);
        check("R8 single break word while low", 12'(got_cnt - n0), 12'd1);
        check("R8 break word", last_word, 12'h400);
        hold_line(1'b1, 192);
        check("R8 no word after line high", 12'(got_cnt - n0), 12'd1);

        @(posedge clk); #1 word_ready = 1'b0;
        send(8, 8'h11, 1'b0, 1'b0, 1'b1);
        check("R9 pending valid", {11'd0, word_valid}, 12'd1);
        check("R9 pending word", word, 12'h011);
        send(8, 8'h22, 1'b0, 1'b0, 1'b1);
        check("R10 overrun on held word", word, 12'h811);
        check("R10 still valid", {11'd0, word_valid}, 12'd1);
        n0 = got_cnt;
        @(posedge clk); #1 word_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 accepted once", 12'(got_cnt - n0), 12'd1);
        check("R10 accepted word", last_word, 12'h811);
        send(8, 8'h33, 1'b0, 1'b0, 1'b1);
        check("R10 overrun cleared", last_word, 12'h033);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule